// File: doc/BRIEF.md
# IO Window Personality Selector

This block decides which of four register personalities answers CPU accesses to the 4 KiB IO window. It watches every CPU write into the window. Only writes to one fixed key offset are acted on. One value on its own returns the machine to the basic personality. Each of the three richer personalities is reached only by a two-byte unlock: a first byte arms a pending state for one target, and the very next key write must carry that target's second byte.

From the active personality the block derives two things. The first is the 28-bit base of the 4 KiB physical page that serves the IO window. The second is a flag that shows whether the enhanced registers, such as the hypervisor trap port, are visible. Both outputs follow a registered personality code, so a completed unlock shows on the outputs after the clock edge that captured the second byte.

Top module: `io_persona_sel`

## Requirements
- R1: After reset the personality code is 0 (basic), the page base is 0xFFD0000, the enhanced flag is low, and no unlock is pending.
- R2: A write of 0x00 to key offset 0x02F selects code 0 at once, from any state, and discards any pending unlock.
- R3: A key write of 0xA5 followed by a key write of 0x96 selects code 1.
- R4: A key write of 0x45 followed by a key write of 0x54 selects code 2.
- R5: A key write of 0x47 followed by a key write of 0x53 selects code 3.
- R6: A first byte on its own never changes the personality; only the matching second byte completes the unlock.
- R7: While an unlock is pending, a key write that is neither 0x00 nor the matching second byte discards the pending unlock, does not arm a new one, and leaves the personality unchanged.
- R8: Cycles without a write, and writes to any offset other than 0x02F, change neither the pending unlock nor the personality.
- R9: The page base equals 0xFFD0000 + code × 0x1000, so codes 0..3 give 0xFFD0000, 0xFFD1000, 0xFFD2000 and 0xFFD3000.
- R10: The enhanced-register flag is high exactly when the code is 2 or 3.
- R11: A second byte written while nothing is pending has no effect.
- R12: The new personality appears on all outputs in the cycle after the clock edge that captures the completing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe into the IO window |
| wr_off | input | 12 | Byte offset of the write inside the IO window |
| wr_data | input | 8 | Write data byte |
| persona | output | 2 | Active personality code: 0 basic, 1 compatible, 2 network, 3 full |
| page_base | output | 28 | Physical base of the 4 KiB page that serves the IO window |
| enh_visible | output | 1 | Enhanced registers (trap port and similar) are visible |

## Verification
The assertions assume that the write strobe, offset and data are known and stable around the sampling edge, and that one write is presented per cycle with no combined or partial strobes. They also assume that reset is held for at least one edge, so that the pending state and the code start from a defined value. The stimulus changes inputs only on the falling clock edge, it always drives the strobe to a defined level, and it holds reset across several edges before the first write. Writes to neighbouring offsets and idle cycles carrying key-like data are mixed in. Both then fall inside the conditions the properties were written for.

// File: rtl/io_persona_pkg.sv
package io_persona_pkg;

  localparam int ADDR_W     = 28;
  localparam int OFF_W      = 12;
  localparam int DATA_W     = 8;
  localparam int PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    PERS_BASIC = 2'd0,
    PERS_COMPAT = 2'd1,
    PERS_NET   = 2'd2,
    PERS_FULL  = 2'd3
  } persona_e;

  typedef enum logic [1:0] {
    ARM_NONE   = 2'd0,
    ARM_COMPAT = 2'd1,
    ARM_NET    = 2'd2,
    ARM_FULL   = 2'd3
  } arm_e;

  localparam logic [DATA_W-1:0] KEY_RESET_BYTE = 8'h00;
  localparam logic [DATA_W-1:0] COMPAT_LEAD    = 8'hA5;
  localparam logic [DATA_W-1:0] COMPAT_TAIL    = 8'h96;
  localparam logic [DATA_W-1:0] NET_LEAD       = 8'h45;
  localparam logic [DATA_W-1:0] NET_TAIL       = 8'h54;
  localparam logic [DATA_W-1:0] FULL_LEAD      = 8'h47;
  localparam logic [DATA_W-1:0] FULL_TAIL      = 8'h53;

  // Which unlock a leading byte arms (ARM_NONE when it is not a lead byte).
  function automatic arm_e lead_target(input logic [DATA_W-1:0] d);
    case (d)
      COMPAT_LEAD: lead_target = ARM_COMPAT;
      NET_LEAD:    lead_target = ARM_NET;
      FULL_LEAD:   lead_target = ARM_FULL;
      default:     lead_target = ARM_NONE;
    endcase
  endfunction

  // Byte that completes a pending unlock.
  function automatic logic [DATA_W-1:0] tail_for(input arm_e a);
    case (a)
      ARM_COMPAT: tail_for = COMPAT_TAIL;
      ARM_NET:    tail_for = NET_TAIL;
      ARM_FULL:   tail_for = FULL_TAIL;
      default:    tail_for = KEY_RESET_BYTE;
    endcase
  endfunction

  function automatic persona_e persona_for(input arm_e a);
    case (a)
      ARM_COMPAT: persona_for = PERS_COMPAT;
      ARM_NET:    persona_for = PERS_NET;
      ARM_FULL:   persona_for = PERS_FULL;
      default:    persona_for = PERS_BASIC;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] page_of(input logic [ADDR_W-1:0] base,
                                                input persona_e p);
    page_of = base + (ADDR_W'(p) << PAGE_SHIFT);
  endfunction

  function automatic logic enh_of(input persona_e p);
    enh_of = (p == PERS_NET) || (p == PERS_FULL);
  endfunction

endpackage

// File: rtl/key_strobe_dec.sv
module key_strobe_dec #(
  parameter int OFF_W = 12,
  parameter logic [OFF_W-1:0] KEY_OFFSET = 12'h02F
) (
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  output logic             key_wr
);
  assign key_wr = wr_en && (wr_off == KEY_OFFSET);
endmodule

// File: rtl/knock_seq.sv
module knock_seq
  import io_persona_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output persona_e          pers_q
);
  arm_e     arm_q, arm_d;
  persona_e pers_d;
  persona_e tgt;

  // Named internal events, used by the next-state logic and the assertions.
  logic clear_ev, fire_ev, abort_ev, arm_ev;

  assign tgt      = persona_for(arm_q);
  assign clear_ev = key_wr && (key_data == KEY_RESET_BYTE);
  assign fire_ev  = key_wr && !clear_ev && (arm_q != ARM_NONE)
                    && (key_data == tail_for(arm_q));
  assign abort_ev = key_wr && !clear_ev && (arm_q != ARM_NONE) && !fire_ev;
  assign arm_ev   = key_wr && !clear_ev && (arm_q == ARM_NONE)
                    && (lead_target(key_data) != ARM_NONE);

  always_comb begin
    arm_d  = arm_q;
    pers_d = pers_q;
    if (clear_ev) begin
      arm_d  = ARM_NONE;
      pers_d = PERS_BASIC;
    end else if (fire_ev) begin
      arm_d  = ARM_NONE;
      pers_d = tgt;
    end else if (abort_ev) begin
      arm_d  = ARM_NONE;
    end else if (arm_ev) begin
      arm_d  = lead_target(key_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= ARM_NONE;
      pers_q <= PERS_BASIC;
    end else begin
      arm_q  <= arm_d;
      pers_q <= pers_d;
    end
  end

  // R6
  change_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pers_q != $past(pers_q)) |-> $past(key_wr));

  // R2
  clear_to_basic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_ev |=> (pers_q == PERS_BASIC) && (arm_q == ARM_NONE));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(arm_q) && $stable(pers_q));

  // R7
  abort_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (arm_q == ARM_NONE) && $stable(pers_q));

  // R12
  fire_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ev |=> (pers_q == $past(tgt)) && (arm_q == ARM_NONE));

  // R11
  lone_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && arm_q == ARM_NONE && key_data != KEY_RESET_BYTE) |=> $stable(pers_q));
endmodule

// File: rtl/persona_page_map.sv
module persona_page_map
  import io_persona_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PAGE_BASE = 28'hFFD0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  persona_e          pers,
  output logic [ADDR_W-1:0] page_base,
  output logic              enh_visible
);
  localparam logic [ADDR_W-1:0] ENH_FLOOR = PAGE_BASE + (ADDR_W'(2) << PAGE_SHIFT);

  assign page_base   = page_of(PAGE_BASE, pers);
  assign enh_visible = enh_of(pers);

  // R9
  page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_base[PAGE_SHIFT-1:0] == '0);

  // R10
  enh_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enh_visible == (page_base >= ENH_FLOOR));
endmodule

// File: rtl/io_persona_sel.sv
module io_persona_sel
  import io_persona_pkg::*;
#(
  parameter logic [OFF_W-1:0]  KEY_OFFSET = 12'h02F,
  parameter logic [ADDR_W-1:0] PAGE_BASE  = 28'hFFD0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        persona,
  output logic [ADDR_W-1:0] page_base,
  output logic              enh_visible
);
  logic     key_wr;
  persona_e pers_q;

  key_strobe_dec #(.OFF_W(OFF_W), .KEY_OFFSET(KEY_OFFSET)) u_dec (
    .wr_en  (wr_en),
    .wr_off (wr_off),
    .key_wr (key_wr)
  );

  knock_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (wr_data),
    .pers_q   (pers_q)
  );

  persona_page_map #(.PAGE_BASE(PAGE_BASE)) u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .pers        (pers_q),
    .page_base   (page_base),
    .enh_visible (enh_visible)
  );

  assign persona = pers_q;

  // R8
  other_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off != KEY_OFFSET) |=> $stable(persona));
endmodule

// File: tb/tb_io_persona_sel.sv
`timescale 1ns/1ps
module tb_io_persona_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_off = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  persona;
  logic [27:0] page_base;
  logic        enh_visible;

  int checks = 0;
  int failures = 0;

  typedef struct { logic [1:0] code; string tag; } exp_t;
  exp_t sb[$];

  io_persona_sel dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
    .wr_data(wr_data), .persona(persona), .page_base(page_base),
    .enh_visible(enh_visible)
  );

  always #2.5 clk = ~clk;

  task automatic compare(input logic [1:0] code, input string tag);
    logic [27:0] eb;
    logic        ee;
    eb = 28'hFFD0000 + 28'(code) * 28'h1000;
    ee = (code == 2'd2) || (code == 2'd3);
    checks++;
    if (persona !== code || page_base !== eb || enh_visible !== ee) begin
      failures++;
      $display("FAIL %s: got code=%0d base=%h enh=%0b, expected code=%0d base=%h enh=%0b",
               tag, persona, page_base, enh_visible, code, eb, ee);
    end
  endtask

  // Driver: one write per call, expectation queued for the capturing edge.
  task automatic put(input logic en, input logic [11:0] off, input logic [7:0] d,
                     input logic [1:0] exp_code, input string tag);
    exp_t it;
    @(negedge clk);
    wr_en = en; wr_off = off; wr_data = d;
    it.code = exp_code; it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
  endtask

  // Monitor: outputs are checked just after the edge that captured the write (R12).
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      compare(it.code, it.tag);
    end
  end

  localparam logic [11:0] KEY = 12'h02F;

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    compare(2'd0, "R1 reset state");

    put(1, KEY, 8'h96, 2'd0, "R11 lone tail after reset (R1 nothing pending)");
    put(1, KEY, 8'hA5, 2'd0, "R6 lead byte alone");
    put(1, KEY, 8'h96, 2'd1, "R3 compat unlock R9 R12");
    put(1, KEY, 8'h45, 2'd1, "R6 net lead alone");
    put(1, KEY, 8'h54, 2'd2, "R4 net unlock R10 R9");
    put(1, KEY, 8'h47, 2'd2, "R6 full lead alone");
    put(1, KEY, 8'h53, 2'd3, "R5 full unlock R10 R9");
    put(1, KEY, 8'hA5, 2'd3, "R6 compat lead in full");
    put(1, KEY, 8'h53, 2'd3, "R7 wrong tail keeps personality");
    put(1, KEY, 8'h96, 2'd3, "R7 pending discarded");
    put(1, KEY, 8'h45, 2'd3, "R6 net lead");
    put(1, 12'h02E, 8'h54, 2'd3, "R8 neighbour offset ignored");
    put(1, 12'h640, 8'h54, 2'd3, "R8 trap offset ignored");
    put(0, KEY, 8'h54, 2'd3, "R8 no strobe ignored");
    put(1, KEY, 8'h54, 2'd2, "R8 pending survived other writes");
    put(1, KEY, 8'h47, 2'd2, "R6 full lead");
    put(1, KEY, 8'h00, 2'd0, "R2 reset byte selects basic");
    put(1, KEY, 8'h53, 2'd0, "R2 pending dropped by reset byte");
    put(1, KEY, 8'h47, 2'd0, "R6 full lead");
    put(1, KEY, 8'h47, 2'd0, "R7 lead as wrong tail");
    put(1, KEY, 8'h53, 2'd0, "R7 no new arm from wrong tail");
    put(1, KEY, 8'hA5, 2'd0, "R6 compat lead");
    put(1, KEY, 8'h96, 2'd1, "R3 compat again");
    put(1, KEY, 8'h00, 2'd0, "R2 reset byte from compat");
    put(0, 12'h000, 8'h00, 2'd0, "R8 idle");
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule